// File: doc/BRIEF.md
# Recursive Split-Operand Unsigned Multiplier

This block multiplies two unsigned operands of WIDTH bits and returns the full product of 2*WIDTH bits. It has no clock: the product settles combinationally from the operands. WIDTH is a power of two, from 2 up to 128.

Each operand is cut into an upper half and a lower half. Four half-width products are formed: lower by lower, the two cross terms, and upper by upper. Each of them is built the same way again, down to a 2x2 cell made of AND gates and two half adders. At each level the sub-products are merged by carry look-ahead adders. These adders have 4-bit generate/propagate groups and a flat group-carry unit, so the carry does not ripple from one end of the word to the other.

Top module: `vcm_mult`

## Requirements
- R1: For every pair of operands, `product` equals the unsigned product op_a * op_b in all 2*WIDTH bits. No internal addition overflows its result field.
- R2: WIDTH must be a power of two of at least 2, or elaboration stops with an error. The product port is exactly 2*WIDTH bits wide.
- R3: In the 2x2 cell, bit 0 is a0&b0. Bit 1 is the XOR of a0&b1 and a1&b0. Bit 2 is the XOR of a1&b1 with the AND of the two cross terms. Bit 3 is the AND of a1&b1 with that carry. The cell's value never exceeds 9.
- R4: If either operand is zero, the product is zero.
- R5: If one operand is 1, the product equals the other operand, zero-extended to 2*WIDTH bits.
- R6: All-ones times all-ones gives 2^(2W) - 2^(W+1) + 1. Its top bit is 1, bits W..1 are 0 and bit 0 is 1.
- R7: Product bits [WIDTH/2-1:0] depend only on the lower halves of the operands. Changing the upper halves leaves them unchanged.
- R8: The product follows an operand change within the same clock period, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | Unsigned multiplicand |
| op_b | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Unsigned full-width product |

## Verification
The bench runs all sixteen cases of the 2-bit cell and compares every output bit with its AND/XOR formula. A half adder with a swapped sum and carry, or a missing carry, fails there at once. All-ones operands drive the largest carry out of the cross-term addition. A design that dropped one of the two extra carry bits, or cut the upper addition too narrow, would lose high product bits exactly in that case. The zero and identity operands catch a sub-product that is placed at the wrong offset. A check that changes only the upper halves shows whether the low-by-low result really reaches the low bits unchanged. Random operands at widths 16 and 32 cover the general case.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
    // carry look-ahead group size in bits
    localparam int unsigned CLA_GRP = 4;

    function automatic bit is_pow2_ge2(input int unsigned v);
        return (v >= 2) && ((v & (v - 1)) == 0);
    endfunction

    function automatic int unsigned grp_count(input int unsigned w);
        return (w + CLA_GRP - 1) / CLA_GRP;
    endfunction
endpackage

// File: rtl/vcm_cla.sv
module vcm_cla
    import vcm_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] add_a,
    input  logic [W-1:0] add_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int unsigned NG = grp_count(W);
    localparam int unsigned WP = NG * CLA_GRP;

    logic [WP-1:0] a_pad, b_pad, prop, gen;
    logic [NG-1:0] grp_g, grp_p;
    logic [NG:0]   grp_c;
    logic [WP:0]   bit_c;

    // pad operands up to a whole number of groups
    always_comb begin
        a_pad = '0;
        b_pad = '0;
        a_pad[W-1:0] = add_a;
        b_pad[W-1:0] = add_b;
        prop = a_pad ^ b_pad;
        gen  = a_pad & b_pad;
    end

    // group generate / propagate
    always_comb begin
        for (int j = 0; j < int'(NG); j++) begin
            logic gacc;
            logic pacc;
            gacc = 1'b0;
            pacc = 1'b1;
            for (int i = 0; i < int'(CLA_GRP); i++) begin
                gacc = gen[j*CLA_GRP+i] | (prop[j*CLA_GRP+i] & gacc);
                pacc = pacc & prop[j*CLA_GRP+i];
            end
            grp_g[j] = gacc;
            grp_p[j] = pacc;
        end
    end

    // flat group-level look-ahead: each group carry is a sum of products
    always_comb begin
        grp_c[0] = cin;
        for (int j = 0; j < int'(NG); j++) begin
            logic acc;
            logic term;
            acc = cin;
            for (int m = 0; m <= j; m++) acc = acc & grp_p[m];
            for (int k = 0; k <= j; k++) begin
                term = grp_g[k];
                for (int m = k + 1; m <= j; m++) term = term & grp_p[m];
                acc = acc | term;
            end
            grp_c[j+1] = acc;
        end
    end

    // carries inside each group, seeded by the group carry
    always_comb begin
        bit_c = '0;
        for (int j = 0; j < int'(NG); j++) begin
            bit_c[j*CLA_GRP] = grp_c[j];
            for (int i = 1; i < int'(CLA_GRP); i++) begin
                bit_c[j*CLA_GRP+i] = gen[j*CLA_GRP+i-1]
                                   | (prop[j*CLA_GRP+i-1] & bit_c[j*CLA_GRP+i-1]);
            end
        end
        bit_c[WP] = grp_c[NG];
    end

    assign sum  = prop[W-1:0] ^ bit_c[W-1:0];
    assign cout = bit_c[W];

    always_comb begin
        AST_CLA_SUM: assert ({cout, sum} == ({1'b0, add_a} + {1'b0, add_b} + (W+1)'(cin))); // R1
    end
endmodule

// File: rtl/vcm_leaf2x2.sv
module vcm_leaf2x2 (
    input  logic [1:0] la,
    input  logic [1:0] lb,
    output logic [3:0] ly
);
    logic cross_lo, cross_hi, ha0_c, top_pp;

    always_comb begin
        cross_lo = la[0] & lb[1];
        cross_hi = la[1] & lb[0];
        top_pp   = la[1] & lb[1];
        ha0_c    = cross_lo & cross_hi;
        ly[0]    = la[0] & lb[0];
        ly[1]    = cross_lo ^ cross_hi;
        ly[2]    = top_pp ^ ha0_c;
        ly[3]    = top_pp & ha0_c;
    end

    always_comb begin
        AST_LEAF_RANGE: assert (ly <= 4'd9); // R3
    end
endmodule

// File: rtl/vcm_stage.sv
module vcm_stage #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0]   sa,
    input  logic [N-1:0]   sb,
    output logic [2*N-1:0] sy
);
    localparam int unsigned H = N / 2;

    generate
        if (N == 2) begin : g_leaf
            vcm_leaf2x2 u_leaf (.la(sa), .lb(sb), .ly(sy));
        end else begin : g_split
            logic [N-1:0]   pp_ll, pp_lh, pp_hl, pp_hh;
            logic [N:0]     cross_s1;
            logic [N+1:0]   cross_s2;
            logic [N-1:0]   upper_sum;
            logic           c1_out, c2_out, c3_out;
            logic [H+1:0]   cross_carry;

            vcm_stage #(.N(H)) u_ll (.sa(sa[H-1:0]), .sb(sb[H-1:0]), .sy(pp_ll));
            vcm_stage #(.N(H)) u_lh (.sa(sa[H-1:0]), .sb(sb[N-1:H]), .sy(pp_lh));
            vcm_stage #(.N(H)) u_hl (.sa(sa[N-1:H]), .sb(sb[H-1:0]), .sy(pp_hl));
            vcm_stage #(.N(H)) u_hh (.sa(sa[N-1:H]), .sb(sb[N-1:H]), .sy(pp_hh));

            // cross terms summed first, then the carry of low x low added
            vcm_cla #(.W(N+1)) u_add_x1 (
                .add_a ((N+1)'(pp_lh)),
                .add_b ((N+1)'(pp_hl)),
                .cin   (1'b0),
                .sum   (cross_s1),
                .cout  (c1_out)
            );
            vcm_cla #(.W(N+2)) u_add_x2 (
                .add_a ((N+2)'(cross_s1)),
                .add_b ((N+2)'(pp_ll[N-1:H])),
                .cin   (1'b0),
                .sum   (cross_s2),
                .cout  (c2_out)
            );

            assign cross_carry = cross_s2[N+1:H];

            vcm_cla #(.W(N)) u_add_hi (
                .add_a (pp_hh),
                .add_b (N'(cross_carry)),
                .cin   (1'b0),
                .sum   (upper_sum),
                .cout  (c3_out)
            );

            assign sy = {upper_sum, cross_s2[H-1:0], pp_ll[H-1:0]};

            always_comb begin
                AST_CROSS_FITS: assert (!c1_out && !c2_out); // R1
                AST_NO_OVERFLOW: assert (!c3_out); // R1
                AST_LOW_PASS: assert (sy[H-1:0] == pp_ll[H-1:0]); // R7
            end
        end
    endgenerate
endmodule

// File: rtl/vcm_mult.sv
module vcm_mult
    import vcm_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] product
);
    generate
        if (!is_pow2_ge2(WIDTH)) begin : g_bad_width
            $error("vcm_mult: WIDTH must be a power of two of at least 2"); // R2
        end
    endgenerate

    vcm_stage #(.N(WIDTH)) u_core (.sa(op_a), .sb(op_b), .sy(product));

    always_comb begin
        if (op_a == '0 || op_b == '0) begin
            AST_ZERO_ANNIHILATES: assert (product == '0); // R4
        end
        if (op_a == WIDTH'(1)) begin
            AST_UNIT_IDENTITY: assert (product == (2*WIDTH)'(op_b)); // R5
        end
    end
endmodule

// File: tb/vcm_mult_bench.sv
module vcm_mult_bench;
    localparam time CYC = 20ns;

    logic clk = 1'b0;
    always #(CYC/2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [1:0]  a2, b2;
    logic [3:0]  y2;
    logic [15:0] a16, b16;
    logic [31:0] y16;
    logic [31:0] a32, b32;
    logic [63:0] y32;

    vcm_mult #(.WIDTH(2))  u_vcm_mult_w2 (.op_a(a2),  .op_b(b2),  .product(y2));
    vcm_mult               u_vcm_mult    (.op_a(a16), .op_b(b16), .product(y16));
    vcm_mult #(.WIDTH(32)) u_vcm_mult_w32(.op_a(a32), .op_b(b32), .product(y32));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive just after a rising edge, sample mid-period
    task automatic drive16(input logic [15:0] a, input logic [15:0] b);
        @(posedge clk); #1;
        a16 = a; b16 = b;
        #(CYC/4);
    endtask

    task automatic drive32(input logic [31:0] a, input logic [31:0] b);
        @(posedge clk); #1;
        a32 = a; b32 = b;
        #(CYC/4);
    endtask

    task automatic t_idle_state();
        @(posedge clk); #1;
        a2 = '0; b2 = '0; a16 = '0; b16 = '0; a32 = '0; b32 = '0;
        #(CYC/4);
        check("R4 idle w2", 64'(y2), 64'd0);
        check("R4 idle w16", 64'(y16), 64'd0);
        check("R4 idle w32", y32, 64'd0);
        check("R2 port width w16", 64'($bits(y16)), 64'd32);
        check("R2 port width w32", 64'($bits(y32)), 64'd64);
    endtask

    task automatic t_leaf_exhaustive();
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                logic [3:0] e;
                logic c0;
                @(posedge clk); #1;
                a2 = 2'(i); b2 = 2'(j);
                #(CYC/4);
                c0 = (a2[0] & b2[1]) & (a2[1] & b2[0]);
                e[0] = a2[0] & b2[0];
                e[1] = (a2[0] & b2[1]) ^ (a2[1] & b2[0]);
                e[2] = (a2[1] & b2[1]) ^ c0;
                e[3] = (a2[1] & b2[1]) & c0;
                check("R3 leaf bits", 64'(y2), 64'(e));
                check("R1 leaf value", 64'(y2), 64'(i * j));
            end
        end
    endtask

    task automatic t_zero();
        drive16(16'h0000, 16'hBEEF);
        check("R4 zero a w16", 64'(y16), 64'd0);
        drive16(16'hFFFF, 16'h0000);
        check("R4 zero b w16", 64'(y16), 64'd0);
        drive32(32'h0, 32'hFFFF_FFFF);
        check("R4 zero a w32", y32, 64'd0);
    endtask

    task automatic t_one();
        drive16(16'h0001, 16'hA5C3);
        check("R5 one a w16", 64'(y16), 64'h0000_A5C3);
        drive16(16'hFFFF, 16'h0001);
        check("R5 one b w16", 64'(y16), 64'h0000_FFFF);
        drive32(32'h0000_0001, 32'hDEAD_BEEF);
        check("R5 one a w32", y32, 64'h0000_0000_DEAD_BEEF);
    endtask

    task automatic t_all_ones();
        drive16(16'hFFFF, 16'hFFFF);
        check("R6 ones w16", 64'(y16), 64'h0000_0000_FFFE_0001);
        drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R6 ones w32", y32, 64'hFFFF_FFFE_0000_0001);
        @(posedge clk); #1;
        a2 = 2'b11; b2 = 2'b11;
        #(CYC/4);
        check("R6 ones w2", 64'(y2), 64'd9);
    endtask

    task automatic t_low_quarter();
        logic [7:0] ref_lo;
        drive16(16'h00B7, 16'h0035);
        ref_lo = y16[7:0];
        check("R7 low base", 64'(y16), 64'(16'h00B7) * 64'(16'h0035));
        drive16(16'hFFB7, 16'h9A35);
        check("R7 low unchanged", 64'(y16[7:0]), 64'(ref_lo));
        check("R1 after high change", 64'(y16), 64'(16'hFFB7) * 64'(16'h9A35));
    endtask

    task automatic t_same_period();
        @(posedge clk); #1;
        a16 = 16'h1234; b16 = 16'h5678;
        #2;
        check("R8 settle 1", 64'(y16), 64'(16'h1234) * 64'(16'h5678));
        a16 = 16'h8001; b16 = 16'h7FFF;
        #2;
        check("R8 settle 2 no edge", 64'(y16), 64'(16'h8001) * 64'(16'h7FFF));
    endtask

    task automatic t_random();
        for (int k = 0; k < 300; k++) begin
            logic [15:0] ra, rb;
            logic [31:0] qa, qb;
            ra = 16'($urandom); rb = 16'($urandom);
            qa = $urandom; qb = $urandom;
            @(posedge clk); #1;
            a16 = ra; b16 = rb; a32 = qa; b32 = qb;
            #(CYC/4);
            check("R1 random w16", 64'(y16), 64'(ra) * 64'(rb));
            check("R1 random w32", y32, 64'(qa) * 64'(qb));
        end
    endtask

    task automatic t_carry_edges();
        drive32(32'hFFFF_0000, 32'hFFFF_FFFF);
        check("R1 carry edge 1", y32, 64'(32'hFFFF_0000) * 64'(32'hFFFF_FFFF));
        drive32(32'h0000_FFFF, 32'hFFFF_FFFF);
        check("R1 carry edge 2", y32, 64'(32'h0000_FFFF) * 64'(32'hFFFF_FFFF));
        drive32(32'h8000_0000, 32'h8000_0000);
        check("R1 top bits", y32, 64'h4000_0000_0000_0000);
        drive16(16'h00FF, 16'hFF00);
        check("R1 cross only w16", 64'(y16), 64'(16'h00FF) * 64'(16'hFF00));
    endtask

    initial begin
        t_idle_state();
        t_leaf_exhaustive();
        t_zero();
        t_one();
        t_all_ones();
        t_low_quarter();
        t_same_period();
        t_carry_edges();
        t_random();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule